// File: doc/BRIEF.md
# Serial Flash Status Register Guard

This block keeps the three 8-bit status registers of a serial flash device. It decides whether a status register write command can change them. The command decoder gives it single-cycle strobes for write enable, write disable, volatile write enable and status write, with a register select and a data byte. The block returns the live register contents and the enables that set what the shared write-protect and hold/reset pins do.

Each register exists in two banks. A non-volatile image is loaded at power-up, which is the synchronous reset `rst_n`. A volatile working copy is what the device reads and what protection decisions use. The normal write path needs the write enable latch. It updates both banks, then holds BUSY for `TW_CYCLES` cycles and clears the latch when BUSY ends. The volatile path is armed by a separate strobe. It changes only the working copy, completes at once, and is undone by a software reset (`soft_rst`), which reloads the working copy from the image.

Top module: `sr_guard`

## Requirements
- R1: WEL (register 1 bit 1) is 0 after power-up. `cmd_wren` sets it. `cmd_wrdi`, `op_done` and `soft_rst` clear it. Each change is visible the cycle after the strobe.
- R2: `cmd_vwren` leaves WEL unchanged and arms only the next status write. That write updates only the working copy, in the next cycle, without BUSY. A second write with no new enable is ignored. `soft_rst` restores the image value.
- R3: With WEL=1 and nothing armed, an accepted status write updates both banks. BUSY (register 1 bit 0) is then 1 for exactly `TW_CYCLES` cycles, and WEL is cleared when BUSY drops. The value survives `soft_rst`.
- R4: The protect mode is SRP1:SRP0 (register 2 bit 0 : register 1 bit 7). In mode 00, `wp_n` has no effect. In mode 01, `wp_n`=0 rejects every status write, unless QE (register 2 bit 1) is 1, which disables the pin. A write without WEL or an armed volatile enable is always rejected.
- R5: Mode 10 rejects every status write. A software reset does not clear it. At power-up, an image that holds mode 10 is loaded as mode 00.
- R6: Mode 11 rejects every status write, including after a software reset.
- R7: The lock bits (register 2 bits 5..2) can be set one at a time and are never cleared by a write.
- R8: While `qpi_mode`=1, QE reads as 1, and a status write cannot clear the stored QE.
- R9: With QE=0, `wp_fn_en`=1. With QE=0, the hold/reset select bit (register 3 bit 7) picks hold (0, `hold_fn_en`) or reset (1, `rst_fn_en`). With QE=1, all three are 0 and `quad_en`=1.
- R10: BUSY, WEL, register 2 bit 7 and register 3 bits 6..3 are not changed by writes and read as 0 when not driven by status. The writable fields are register 1 bits 7..2, register 2 bits 6..0, and register 3 bits 7, 2..0 (`wr_sel` 0, 1, 2 selects register 1, 2, 3; 3 selects none).
- R11: While BUSY=1, write enable, write disable, volatile enable and status write strobes are ignored.
- R12: After power-up, the working copy equals the masked image given by `INIT_SR1..3`. With default parameters, all three registers read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-up reset |
| soft_rst | input | 1 | Software reset strobe: reload working copy, clear WEL, BUSY, arm |
| cmd_wren | input | 1 | Write enable strobe |
| cmd_wrdi | input | 1 | Write disable strobe |
| cmd_vwren | input | 1 | Volatile write enable strobe |
| cmd_wrsr | input | 1 | Status write strobe |
| wr_sel | input | 2 | Target register of the status write |
| wr_data | input | 8 | Status write data |
| op_done | input | 1 | Program or erase finished, clears WEL |
| qpi_mode | input | 1 | Device is in four-wire command mode |
| wp_n | input | 1 | Write-protect pin, active low |
| sr1 | output | 8 | Status register 1 |
| sr2 | output | 8 | Status register 2 |
| sr3 | output | 8 | Status register 3 |
| quad_en | output | 1 | IO2/IO3 act as data lines |
| wp_fn_en | output | 1 | Pin acts as write protect |
| hold_fn_en | output | 1 | Pin acts as hold |
| rst_fn_en | output | 1 | Pin acts as reset |

## Verification
The acceptance decision is swept over all four protect modes, both pin levels and both QE values. Each point uses three enable choices: none, latch, and volatile arm. The expected result comes from the mode rule, and BUSY separates the two write paths. Directed sequences then cover lock persistence across software reset, power-up remapping of mode 10, sticky lock bits, QE held in four-wire mode, pin-function selection, masked bits, and commands issued during BUSY.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
    // Shared widths, field positions and writable masks of the status registers.
    localparam int SR_W   = 8;
    localparam int N_REG  = 3;
    localparam int SEL_W  = 2;

    localparam int R1_SRP0 = 7;
    localparam int R2_SRP1 = 0;
    localparam int R2_QE   = 1;
    localparam int R3_HRS  = 7;

    localparam logic [SR_W-1:0] LB_MASK = 8'h3C;
    localparam logic [SR_W-1:0] QE_MASK = 8'h02;

    function automatic logic [SR_W-1:0] wmask(input int idx);
        case (idx)
            0:       return 8'hFC;
            1:       return 8'h7F;
            default: return 8'h87;
        endcase
    endfunction
endpackage

// File: rtl/sr_access.sv
// Decides whether a status write is taken and on which path.
// Assumes srp/qe come from the working copy and strobes are one cycle wide.
module sr_access (
    input  logic [1:0] srp,
    input  logic       qe,
    input  logic       wp_n,
    input  logic       wel,
    input  logic       vol_armed,
    input  logic       busy,
    input  logic       wrsr_valid,
    output logic       acc_nv,
    output logic       acc_vol
);
    logic locked;

    // Protect-mode evaluation: modes 1x always lock, 01 locks on low pin unless quad.
    always_comb begin
        locked  = srp[1] | ((srp == 2'b01) & ~qe & ~wp_n);
        acc_vol = wrsr_valid & ~busy & ~locked & vol_armed;
        acc_nv  = wrsr_valid & ~busy & ~locked & ~vol_armed & wel;
    end

    always_comb begin
        a_r4_wp_pin_lock: assert (!((srp == 2'b01) && !qe && !wp_n && (acc_nv || acc_vol)));
        a_r6_otp_lock: assert (!((srp == 2'b11) && (acc_nv || acc_vol)));
    end
endmodule

// File: rtl/sr_merge.sv
// Builds the next value of one status register from a base value and write data.
// Assumes base already has non-writable bits at 0; lock bits are sticky, QE held in QPI.
module sr_merge
    import sr_guard_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [SR_W-1:0] base,
    input  logic [SR_W-1:0] data,
    input  logic            qpi,
    output logic [SR_W-1:0] nxt
);
    localparam logic [SR_W-1:0] M   = wmask(IDX);
    localparam logic [SR_W-1:0] LBM = (IDX == 1) ? LB_MASK : '0;
    localparam logic [SR_W-1:0] QEM = (IDX == 1) ? QE_MASK : '0;

    // Field merge: writable bits from data, OTP bits ORed, QE forced in QPI.
    always_comb begin
        nxt = (base & ~M) | (data & M) | (base & LBM) | ({SR_W{qpi}} & QEM);
    end
endmodule

// File: rtl/sr_busy_timer.sv
// Counts the non-volatile write time; busy while non-zero, done on the last cycle.
// Assumes start is only raised while not busy and TW >= 1.
module sr_busy_timer #(
    parameter int TW = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic start,
    output logic busy,
    output logic done
);
    localparam int CW = $clog2(TW + 1);
    logic [CW-1:0] cnt_q;

    // Down-counter loaded on an accepted non-volatile write.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)   cnt_q <= '0;
        else if (start)      cnt_q <= CW'(TW);
        else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
    assign done = (cnt_q == CW'(1));

    a_r3_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(TW));
endmodule

// File: rtl/sr_guard.sv
// Status register bank with write-protection control for a serial flash.
// Assumes decoded single-cycle strobes; rst_n models power-up, soft_rst a software reset.
module sr_guard
    import sr_guard_pkg::*;
#(
    parameter int             TW_CYCLES = 16,
    parameter logic [SR_W-1:0] INIT_SR1 = 8'h00,
    parameter logic [SR_W-1:0] INIT_SR2 = 8'h00,
    parameter logic [SR_W-1:0] INIT_SR3 = 8'h00
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            soft_rst,
    input  logic            cmd_wren,
    input  logic            cmd_wrdi,
    input  logic            cmd_vwren,
    input  logic            cmd_wrsr,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SR_W-1:0] wr_data,
    input  logic            op_done,
    input  logic            qpi_mode,
    input  logic            wp_n,
    output logic [SR_W-1:0] sr1,
    output logic [SR_W-1:0] sr2,
    output logic [SR_W-1:0] sr3,
    output logic            quad_en,
    output logic            wp_fn_en,
    output logic            hold_fn_en,
    output logic            rst_fn_en
);
    localparam logic [SR_W-1:0] P1  = INIT_SR1 & wmask(0);
    localparam logic [SR_W-1:0] P2R = INIT_SR2 & wmask(1);
    localparam logic [SR_W-1:0] P2  = (P2R[R2_SRP1] && !P1[R1_SRP0]) ? (P2R & 8'hFE) : P2R;
    localparam logic [SR_W-1:0] P3  = INIT_SR3 & wmask(2);
    localparam logic [N_REG-1:0][SR_W-1:0] PWR_IMG = {P3, P2, P1};

    logic [N_REG-1:0][SR_W-1:0] nv_q, vol_q, merged;
    logic wel_q, arm_q, busy, busy_done, acc_nv, acc_vol, wrsr_valid, qe;
    logic [1:0] srp;

    assign srp        = {vol_q[1][R2_SRP1], vol_q[0][R1_SRP0]};
    assign qe         = vol_q[1][R2_QE] | qpi_mode;
    assign wrsr_valid = cmd_wrsr && (wr_sel < SEL_W'(N_REG));

    sr_access u_access (
        .srp(srp), .qe(qe), .wp_n(wp_n), .wel(wel_q), .vol_armed(arm_q),
        .busy(busy), .wrsr_valid(wrsr_valid), .acc_nv(acc_nv), .acc_vol(acc_vol)
    );

    sr_busy_timer #(.TW(TW_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .start(acc_nv),
        .busy(busy), .done(busy_done)
    );

    for (genvar g = 0; g < N_REG; g++) begin : g_merge
        sr_merge #(.IDX(g)) u_merge (
            .base(acc_vol ? vol_q[g] : nv_q[g]), .data(wr_data),
            .qpi(qpi_mode), .nxt(merged[g])
        );
    end

    // Write enable latch: set by enable, cleared by disable, op end, write end, reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                               wel_q <= 1'b0;
        else if (soft_rst || busy_done || op_done) wel_q <= 1'b0;
        else if (!busy && cmd_wrdi)                wel_q <= 1'b0;
        else if (!busy && cmd_wren)                wel_q <= 1'b1;
    end

    // Volatile arm: set by its enable, consumed by the next status write.
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst)          arm_q <= 1'b0;
        else if (!busy && cmd_wrsr)      arm_q <= 1'b0;
        else if (!busy && cmd_vwren)     arm_q <= 1'b1;
    end

    // Register banks: image loaded at power-up, working copy reloaded on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nv_q  <= PWR_IMG;
            vol_q <= PWR_IMG;
        end else if (soft_rst) begin
            vol_q <= nv_q;
        end else begin
            for (int i = 0; i < N_REG; i++) begin
                if ((acc_nv || acc_vol) && (wr_sel == SEL_W'(i))) vol_q[i] <= merged[i];
                if (acc_nv && (wr_sel == SEL_W'(i)))              nv_q[i]  <= merged[i];
            end
        end
    end

    // Read-out and pin-function selection.
    always_comb begin
        sr1        = (vol_q[0] & wmask(0)) | {6'b0, wel_q, busy};
        sr2        = (vol_q[1] & wmask(1)) | ({SR_W{qpi_mode}} & QE_MASK);
        sr3        = vol_q[2] & wmask(2);
        quad_en    = qe;
        wp_fn_en   = ~qe;
        hold_fn_en = ~qe & ~vol_q[2][R3_HRS];
        rst_fn_en  = ~qe & vol_q[2][R3_HRS];
    end

    a_r1_wel_set: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wren && !busy && !soft_rst && !op_done && !cmd_wrdi) |=> wel_q);
    a_r3_wel_drop: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !wel_q);
    a_r7_lb_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        acc_nv |=> ((nv_q[1] & LB_MASK) & $past(nv_q[1])) == ($past(nv_q[1]) & LB_MASK));
    a_r6_image_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (srp == 2'b11 && nv_q[1][R2_SRP1] && nv_q[0][R1_SRP0]) |=> $stable(nv_q));
    a_r8_qe_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((acc_nv || acc_vol) && qpi_mode && wr_sel == 2'd1 && !soft_rst) |=> vol_q[1][R2_QE]);
endmodule

// File: tb/tb_sr_guard.sv
module tb_sr_guard;
    localparam int TW = 4;

    logic clk = 1'b0, rst_n = 1'b0, soft_rst = 1'b0;
    logic cmd_wren = 0, cmd_wrdi = 0, cmd_vwren = 0, cmd_wrsr = 0;
    logic [1:0] wr_sel = 2'd3;
    logic [7:0] wr_data = 8'h00;
    logic op_done = 0, qpi_mode = 0, wp_n = 1;
    logic [7:0] sr1, sr2, sr3, l1, l2, l3;
    logic quad_en, wp_fn_en, hold_fn_en, rst_fn_en, lq, lw, lh, lr;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    sr_guard #(.TW_CYCLES(TW)) dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wren(cmd_wren),
        .cmd_wrdi(cmd_wrdi), .cmd_vwren(cmd_vwren), .cmd_wrsr(cmd_wrsr),
        .wr_sel(wr_sel), .wr_data(wr_data), .op_done(op_done), .qpi_mode(qpi_mode),
        .wp_n(wp_n), .sr1(sr1), .sr2(sr2), .sr3(sr3), .quad_en(quad_en),
        .wp_fn_en(wp_fn_en), .hold_fn_en(hold_fn_en), .rst_fn_en(rst_fn_en));

    // Image holding protect mode 10 (register 2 bit 0 set, register 1 bit 7 clear).
    sr_guard #(.TW_CYCLES(TW), .INIT_SR2(8'h01)) dut_lk (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cmd_wren(cmd_wren),
        .cmd_wrdi(cmd_wrdi), .cmd_vwren(cmd_vwren), .cmd_wrsr(cmd_wrsr),
        .wr_sel(wr_sel), .wr_data(wr_data), .op_done(op_done), .qpi_mode(qpi_mode),
        .wp_n(wp_n), .sr1(l1), .sr2(l2), .sr3(l3), .quad_en(lq),
        .wp_fn_en(lw), .hold_fn_en(lh), .rst_fn_en(lr));

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic por();
        rst_n = 0; qpi_mode = 0; wp_n = 1;
        repeat (2) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
    endtask
    task automatic wren();  cmd_wren = 1;  @(negedge clk); cmd_wren = 0;  endtask
    task automatic wrdi();  cmd_wrdi = 1;  @(negedge clk); cmd_wrdi = 0;  endtask
    task automatic vwren(); cmd_vwren = 1; @(negedge clk); cmd_vwren = 0; endtask
    task automatic srst();  soft_rst = 1;  @(negedge clk); soft_rst = 0;  endtask
    task automatic opend(); op_done = 1;   @(negedge clk); op_done = 0;   endtask
    task automatic wrsr(input logic [1:0] s, input logic [7:0] d);
        wr_sel = s; wr_data = d; cmd_wrsr = 1;
        @(negedge clk);
        cmd_wrsr = 0; wr_sel = 2'd3;
    endtask
    task automatic settle(); repeat (TW + 2) @(negedge clk); endtask
    task automatic nvw(input logic [1:0] s, input logic [7:0] d);
        wren(); wrsr(s, d); settle();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        por();
        // R12 reset state
        chk("R12 sr1", sr1, 8'h00); chk("R12 sr2", sr2, 8'h00); chk("R12 sr3", sr3, 8'h00);
        chk("R9 pins reset", {4'b0, quad_en, wp_fn_en, hold_fn_en, rst_fn_en}, 8'h06);
        // R5 power-up of a mode-10 image gives mode 00
        chk("R5 power-up remap", l2, 8'h00);

        // R1 latch
        wren(); chk("R1 set", sr1, 8'h02);
        wrdi(); chk("R1 wrdi clear", sr1, 8'h00);
        wren(); opend(); chk("R1 op_done clear", sr1, 8'h00);
        wren(); srst(); chk("R1 soft reset clear", sr1, 8'h00);

        // R2 volatile path
        vwren(); chk("R2 no WEL", sr1, 8'h00);
        wrsr(2, 8'h81); chk("R2 immediate", sr3, 8'h81); chk("R2 no busy", sr1, 8'h00);
        wrsr(2, 8'h00); chk("R2 one shot", sr3, 8'h81);
        srst(); chk("R2 restored", sr3, 8'h00);

        // R3 non-volatile path
        wren(); wrsr(2, 8'h80);
        chk("R3 busy and WEL", sr1, 8'h03); chk("R3 value", sr3, 8'h80);
        repeat (TW - 1) @(negedge clk); chk("R3 busy last cycle", sr1, 8'h03);
        @(negedge clk); chk("R3 busy end WEL clear", sr1, 8'h00);
        srst(); chk("R3 survives soft reset", sr3, 8'h80);

        // R9 pin select
        chk("R9 reset pin", {4'b0, quad_en, wp_fn_en, hold_fn_en, rst_fn_en}, 8'h05);
        nvw(1, 8'h02);
        chk("R9 quad", {4'b0, quad_en, wp_fn_en, hold_fn_en, rst_fn_en}, 8'h08);

        // R10 masked bits
        por();
        nvw(2, 8'hFF); chk("R10 sr3 mask", sr3, 8'h87);
        nvw(0, 8'h03); chk("R10 status-only", sr1, 8'h00);
        nvw(1, 8'h80); chk("R10 sr2 bit7", sr2, 8'h00);

        // R11 commands during busy
        por();
        wren(); wrsr(2, 8'h01);
        wrsr(2, 8'h80); wren(); vwren(); wrdi();
        settle();
        chk("R11 write ignored", sr3, 8'h01); chk("R11 wren ignored", sr1, 8'h00);
        wrsr(2, 8'h02); chk("R11 vwren ignored", sr3, 8'h01);

        // R7 sticky locks
        por();
        nvw(1, 8'h14); chk("R7 first", sr2, 8'h14);
        nvw(1, 8'h28); chk("R7 accumulate", sr2, 8'h3C);
        nvw(1, 8'h00); chk("R7 no clear", sr2, 8'h3C);

        // R8 QE in QPI
        por();
        qpi_mode = 1; @(negedge clk);
        chk("R8 QE read", sr2, 8'h02);
        nvw(1, 8'h00); qpi_mode = 0; @(negedge clk);
        chk("R8 QE kept", sr2, 8'h02);

        // R5 mode 10 persists across soft reset
        por();
        nvw(1, 8'h01); chk("R5 mode set", sr2, 8'h01);
        nvw(2, 8'h01); chk("R5 locked", sr3, 8'h00);
        srst(); nvw(2, 8'h01); chk("R5 locked after soft reset", sr3, 8'h00);

        // R6 mode 11
        por();
        nvw(0, 8'h80); nvw(1, 8'h01); chk("R6 mode set", sr1, 8'h80);
        srst(); nvw(2, 8'h01); chk("R6 locked", sr3, 8'h00);

        // R4 sweep over mode, pin, QE and enable kind
        for (int m = 0; m < 4; m++)
            for (int p = 0; p < 2; p++)
                for (int q = 0; q < 2; q++)
                    for (int e = 0; e < 3; e++) begin
                        bit lock, acc;
                        por();
                        vwren(); wrsr(0, m[0] ? 8'h80 : 8'h00);
                        vwren(); wrsr(1, {6'b0, q[0], m[1]});
                        wp_n = p[0];
                        if (e == 1) wren();
                        if (e == 2) vwren();
                        wrsr(2, 8'h01);
                        lock = m[1] || (m == 1 && q == 0 && p == 0);
                        acc  = (e != 0) && !lock;
                        chk($sformatf("R4 busy m%0d p%0d q%0d e%0d", m, p, q, e),
                            {7'b0, sr1[0]}, {7'b0, acc && e == 1});
                        settle();
                        chk($sformatf("R4 accept m%0d p%0d q%0d e%0d", m, p, q, e),
                            sr3, {7'b0, acc});
                    end
        summary();
    end
endmodule